// File: doc/BRIEF.md
# UART Receive Buffer with Run-Time Depth Selection

This block is the receive side of a byte-wide UART register file of the classic eight-offset layout. Bytes arrive from a receive source over a valid/ready handshake or, while loopback is selected in the modem-control register, from host writes to the data offset. The host drains them by reading the data offset and polls the line-status offset for data-ready and overrun. Serial bit timing, the baud generator, parity and framing lie outside the block. It keeps only the divisor latch bytes, reached through the divisor-access bit of the line-control register.

The buffer works as a single holding byte after reset. A FIFO-control write with its enable bit set turns it into a 16-entry queue. Any change of that enable bit empties the buffer. Overrun is recorded when a loopback byte meets a full buffer, and it is cleared as a side effect of reading line status.

Register offsets (3-bit address): 0 data (divisor low while divisor access is set), 1 interrupt enable (divisor high while divisor access is set), 2 interrupt identification on read and FIFO control on write, 3 line control, 4 modem control, 5 line status, 6 modem status, 7 scratch. Read data is combinational in the cycle of the access. Side effects (pop, overrun clear, register update) take place at the clock edge that ends the access.

Top module: `uart_rx_path`

## Requirements
- R1: After reset, line status reads 0x60, interrupt identification reads 0x01, the buffer holds at most one byte, and the divisor latch reads 0x0C (low) and 0x00 (high), which is 1843200/9600/16.
- R2: In character mode (FIFO-control bit 0 clear) the buffer accepts one byte from the source, and rx_ready_o then stays low until the byte is read.
- R3: In FIFO mode (FIFO-control bit 0 set) the buffer accepts 16 bytes, drops rx_ready_o at 16, and returns the bytes oldest first.
- R4: A FIFO-control write whose bit 0 differs from the stored enable empties the buffer. A write with the same enable and bit 1 clear keeps the contents. rx_ready_o is low during the emptying cycle.
- R5: A FIFO-control write with bit 0 clear clears the stored control to zero. Interrupt identification reads 0xC1 while FIFO mode is on and 0x01 while it is off.
- R6: A FIFO-control write with bits 0 and 1 both set empties the buffer and leaves FIFO mode on.
- R7: With loopback (modem-control bit 4) set, a data write pushes the byte into the buffer. Source bytes are consumed with rx_ready_o high and are discarded.
- R8: A loopback byte that meets a full buffer is dropped and sets line-status bit 1. Line-status bit 1 reads 0 after the line-status read that reported it.
- R9: Line-status bits 5 and 6 always read 1, and bit 0 reads 1 exactly when the buffer holds data. All other bits read 0.
- R10: A data read of an empty buffer returns 0xFF and leaves the buffer empty.
- R11: While line-control bit 7 is set, offsets 0 and 1 read and write the divisor low and high bytes. No byte is pushed or popped through them.
- R12: Interrupt-enable keeps bits 3:0 and modem-control keeps bits 4:0 of a write. Line control and scratch keep all 8 bits. Writes to line status and modem status have no effect, and modem status reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access strobe, one access per cycle |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, valid in the access cycle |
| rx_valid_i | input | 1 | Receive source has a byte |
| rx_data_i | input | 8 | Receive source byte |
| rx_ready_o | output | 1 | Block takes the source byte this cycle |

## Verification
Some properties are checked by assertions on every cycle. The buffer never holds more than its current depth, and never more than one byte in character mode. An emptying event leaves the count at zero. An overflowing loopback byte always raises overrun, and a line-status read always clears it. Divisor-latch accesses never move the count. Other behaviour can only be shown by the bench's scenarios: the order in which bytes come out, 0xFF on an empty read, the values read back after masking, and whether a FIFO-control write keeps or discards the buffer contents.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 3;

  typedef enum logic [AW-1:0] {
    OFS_DATA = 3'd0,
    OFS_IER  = 3'd1,
    OFS_IDFC = 3'd2,
    OFS_LCR  = 3'd3,
    OFS_MCR  = 3'd4,
    OFS_LSR  = 3'd5,
    OFS_MSR  = 3'd6,
    OFS_SCR  = 3'd7
  } reg_ofs_e;

  localparam int unsigned LCR_DIV_BIT  = 7;
  localparam int unsigned MCR_LOOP_BIT = 4;
  localparam int unsigned FC_EN_BIT    = 0;
  localparam int unsigned FC_RRST_BIT  = 1;
  localparam int unsigned LS_DR_BIT    = 0;
  localparam int unsigned LS_OE_BIT    = 1;
  localparam int unsigned LS_THE_BIT   = 5;
  localparam int unsigned LS_TE_BIT    = 6;

  localparam logic [DW-1:0] FC_KEEP_MASK = 8'hC9;
  localparam logic [DW-1:0] IER_MASK     = 8'h0F;
  localparam logic [DW-1:0] MCR_MASK     = 8'h1F;
  localparam logic [DW-1:0] NO_DATA      = 8'hFF;
  localparam logic [DW-1:0] ID_NONE      = 8'h01;
  localparam logic [DW-1:0] ID_FIFO_ON   = 8'hC0;
endpackage

// File: rtl/rx_buf.sv
module rx_buf
  import uart_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          deep_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic          full_o,
  output logic          empty_o,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q, limit;
  logic          do_push, do_pop;

  assign limit   = deep_i ? CW'(DEPTH) : CW'(1);
  assign full_o  = count_q >= limit;
  assign empty_o = count_q == '0;
  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = count_q;

  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= push_data_i;
  end

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
  a_r2_char_depth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !deep_i |-> count_q <= CW'(1));
  a_r4_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> count_q == '0);
  a_r10_empty_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/rx_ctrl_regs.sv
module rx_ctrl_regs
  import uart_rx_pkg::*;
#(
  parameter int unsigned REF_HZ = 1843200,
  parameter int unsigned BAUD   = 9600,
  localparam int unsigned DIV_RST = REF_HZ / BAUD / 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] ofs_i,
  input  logic [DW-1:0] wdata_i,
  output logic          div_sel_o,
  output logic          loop_o,
  output logic          fifo_en_o,
  output logic          flush_o,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] lcr_q, mcr_q, ier_q, scr_q, dll_q, dlh_q, fc_q;
  logic          fc_wr, en_new;

  assign div_sel_o = lcr_q[LCR_DIV_BIT];
  assign loop_o    = mcr_q[MCR_LOOP_BIT];
  assign fifo_en_o = fc_q[FC_EN_BIT];

  assign fc_wr   = wr_i && (ofs_i == OFS_IDFC);
  assign en_new  = wdata_i[FC_EN_BIT];
  // empty on enable toggle, or on receive reset while enabled
  assign flush_o = fc_wr && ((en_new != fc_q[FC_EN_BIT]) || (en_new && wdata_i[FC_RRST_BIT]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcr_q <= '0;
      mcr_q <= '0;
      ier_q <= '0;
      scr_q <= '0;
      fc_q  <= '0;
      dll_q <= DW'(DIV_RST);
      dlh_q <= DW'(DIV_RST >> DW);
    end else if (wr_i) begin
      unique case (ofs_i)
        OFS_DATA: if (div_sel_o) dll_q <= wdata_i;
        OFS_IER:  if (div_sel_o) dlh_q <= wdata_i;
                  else ier_q <= wdata_i & IER_MASK;
        OFS_IDFC: fc_q  <= en_new ? (wdata_i & FC_KEEP_MASK) : '0;
        OFS_LCR:  lcr_q <= wdata_i;
        OFS_MCR:  mcr_q <= wdata_i & MCR_MASK;
        OFS_SCR:  scr_q <= wdata_i;
        default:  ;
      endcase
    end
  end

  always_comb begin
    unique case (ofs_i)
      OFS_DATA: rdata_o = div_sel_o ? dll_q : '0;
      OFS_IER:  rdata_o = div_sel_o ? dlh_q : ier_q;
      OFS_LCR:  rdata_o = lcr_q;
      OFS_MCR:  rdata_o = mcr_q;
      OFS_SCR:  rdata_o = scr_q;
      default:  rdata_o = '0;
    endcase
  end

  a_r5_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fc_wr && !en_new) |=> fc_q == '0);
  a_r12_ier_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ier_q[DW-1:4] == '0);
endmodule

// File: rtl/rx_line_status.sv
module rx_line_status
  import uart_rx_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ovf_i,
  input  logic          lsr_rd_i,
  input  logic          empty_i,
  output logic [DW-1:0] lsr_o
);
  logic oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       oe_q <= 1'b0;
    else if (ovf_i)    oe_q <= 1'b1;
    else if (lsr_rd_i) oe_q <= 1'b0;
  end

  always_comb begin
    lsr_o             = '0;
    lsr_o[LS_DR_BIT]  = !empty_i;
    lsr_o[LS_OE_BIT]  = oe_q;
    lsr_o[LS_THE_BIT] = 1'b1;
    lsr_o[LS_TE_BIT]  = 1'b1;
  end

  a_r8_oe_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> oe_q);
  a_r8_oe_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_rd_i && !ovf_i) |=> !oe_q);
endmodule

// File: rtl/uart_rx_path.sv
module uart_rx_path
  import uart_rx_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned REF_HZ = 1843200,
  parameter int unsigned BAUD   = 9600,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_req_i,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [7:0]    reg_wdata_i,
  output logic [7:0]    reg_rdata_o,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  output logic          rx_ready_o
);
  logic          wr, rd, div_sel, loop, fifo_en, flush;
  logic          data_wr, data_rd, lsr_rd, lb_push, src_push, push, ovf;
  logic          full, empty;
  logic [DW-1:0] head, push_data, ctrl_rdata, lsr;
  logic [CW-1:0] count;

  assign wr      = reg_req_i && reg_we_i;
  assign rd      = reg_req_i && !reg_we_i;
  assign data_wr = wr && (reg_addr_i == OFS_DATA) && !div_sel;
  assign data_rd = rd && (reg_addr_i == OFS_DATA) && !div_sel;
  assign lsr_rd  = rd && (reg_addr_i == OFS_LSR);

  assign lb_push   = data_wr && loop;
  assign src_push  = !loop && rx_valid_i && !full && !flush;
  assign push      = lb_push || src_push;
  assign push_data = loop ? reg_wdata_i : rx_data_i;
  assign ovf       = lb_push && full;
  // loopback consumes and discards source bytes
  assign rx_ready_o = loop || (!full && !flush);

  rx_ctrl_regs #(.REF_HZ(REF_HZ), .BAUD(BAUD)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr),
    .ofs_i     (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .div_sel_o (div_sel),
    .loop_o    (loop),
    .fifo_en_o (fifo_en),
    .flush_o   (flush),
    .rdata_o   (ctrl_rdata)
  );

  rx_buf #(.DEPTH(DEPTH)) i_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush),
    .deep_i      (fifo_en),
    .push_i      (push),
    .push_data_i (push_data),
    .pop_i       (data_rd),
    .full_o      (full),
    .empty_o     (empty),
    .head_o      (head),
    .count_o     (count)
  );

  rx_line_status i_lsr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ovf_i    (ovf),
    .lsr_rd_i (lsr_rd),
    .empty_i  (empty),
    .lsr_o    (lsr)
  );

  always_comb begin
    unique case (reg_addr_i)
      OFS_DATA: reg_rdata_o = div_sel ? ctrl_rdata : (empty ? NO_DATA : head);
      OFS_IDFC: reg_rdata_o = ID_NONE | (fifo_en ? ID_FIFO_ON : '0);
      OFS_LSR:  reg_rdata_o = lsr;
      OFS_MSR:  reg_rdata_o = '0;
      default:  reg_rdata_o = ctrl_rdata;
    endcase
  end

  a_r11_divisor_no_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i && div_sel && loop && (reg_addr_i == OFS_DATA)) |=> count == $past(count));
  a_r7_source_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop && !(reg_req_i && reg_we_i)) |=> count <= $past(count));
endmodule

// File: tb/test_uart_rx_path.sv
module test_uart_rx_path;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0, rx_valid = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rx_data = '0;
  logic [7:0] rdata;
  logic       rx_ready;
  int         n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  uart_rx_path i_uart_rx_path (
    .clk_i(clk), .rst_ni(rst_n), .reg_req_i(req), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    #2 d = rdata;
    @(posedge clk); #1;
    req = 0;
  endtask

  task automatic src(input logic [7:0] d, output logic taken);
    @(negedge clk);
    rx_valid = 1; rx_data = d;
    #2 taken = rx_ready;
    @(posedge clk); #1;
    rx_valid = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] e);
    logic [7:0] v;
    rd(a, v);
    check(tag, v, e);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic t;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    rd_chk("R1 lsr", 5, 8'h60);
    rd_chk("R1 id", 2, 8'h01);
    wr(3, 8'h80);
    rd_chk("R1 div lo", 0, 8'h0C);
    rd_chk("R1 div hi", 1, 8'h00);
    wr(3, 8'h03);
    rd_chk("R12 lcr", 3, 8'h03);

    // R2 character mode
    src(8'hA5, t); check("R2 first taken", t, 1);
    src(8'h5A, t); check("R2 second refused", t, 0);
    rd_chk("R9 lsr ready", 5, 8'h61);
    rd_chk("R2 data", 0, 8'hA5);
    rd_chk("R10 empty read", 0, 8'hFF);
    rd_chk("R10 still empty", 5, 8'h60);

    // R3/R5 FIFO mode sweep
    wr(2, 8'h01);
    rd_chk("R5 id fifo on", 2, 8'hC1);
    for (int i = 0; i < 17; i++) begin
      src(8'((i * 37 + 11) & 8'hFF), t);
      check("R3 accept", t, (i < 16) ? 1 : 0);
    end
    for (int i = 0; i < 16; i++) rd_chk("R3 order", 0, 8'((i * 37 + 11) & 8'hFF));
    rd_chk("R10 empty after drain", 0, 8'hFF);

    // R4 keep vs flush
    for (int i = 0; i < 3; i++) src(8'(8'h40 + i), t);
    wr(2, 8'h01);
    rd_chk("R4 kept", 0, 8'h40);
    @(negedge clk);
    req = 1; we = 1; addr = 2; wdata = 8'h00; rx_valid = 1; rx_data = 8'h99;
    #2 check("R4 ready low on flush", rx_ready, 0);
    @(posedge clk); #1; req = 0; we = 0; rx_valid = 0;
    rd_chk("R4 flushed", 5, 8'h60);
    rd_chk("R5 id fifo off", 2, 8'h01);
    src(8'h77, t);
    wr(2, 8'h01);
    rd_chk("R4 flush on enable", 5, 8'h60);

    // R6 receive reset
    for (int i = 0; i < 5; i++) src(8'(i), t);
    wr(2, 8'h03);
    rd_chk("R6 flushed", 5, 8'h60);
    rd_chk("R6 still fifo", 2, 8'hC1);

    // R7/R8 loopback
    wr(4, 8'h10);
    rd_chk("R12 mcr", 4, 8'h10);
    src(8'h66, t); check("R7 source ready", t, 1);
    rd_chk("R7 source discarded", 5, 8'h60);
    for (int i = 0; i < 17; i++) wr(0, 8'(8'hE0 ^ i));
    rd_chk("R8 overrun", 5, 8'h63);
    rd_chk("R8 overrun cleared", 5, 8'h61);
    for (int i = 0; i < 16; i++) rd_chk("R7 loop order", 0, 8'(8'hE0 ^ i));
    wr(2, 8'h00);
    wr(0, 8'h31);
    wr(0, 8'h32);
    rd_chk("R8 char overrun", 5, 8'h63);
    rd_chk("R7 char kept first", 0, 8'h31);
    rd_chk("R8 cleared", 5, 8'h60);

    // R11 divisor access
    wr(3, 8'h80);
    wr(0, 8'h34);
    wr(1, 8'h12);
    rd_chk("R11 no push", 5, 8'h60);
    rd_chk("R11 div lo", 0, 8'h34);
    rd_chk("R11 div hi", 1, 8'h12);
    wr(3, 8'h00);
    rd_chk("R11 ier unaffected", 1, 8'h00);
    wr(0, 8'h55);
    wr(3, 8'h80);
    rd_chk("R11 no pop", 0, 8'h34);
    wr(3, 8'h00);
    rd_chk("R11 byte intact", 0, 8'h55);

    // R12 masks and ignored writes
    wr(1, 8'hFF); rd_chk("R12 ier mask", 1, 8'h0F);
    wr(4, 8'hFF); rd_chk("R12 mcr mask", 4, 8'h1F);
    wr(4, 8'h00);
    wr(5, 8'hFF); rd_chk("R12 lsr write ignored", 5, 8'h60);
    wr(6, 8'hFF); rd_chk("R12 msr zero", 6, 8'h00);
    for (int v = 0; v < 256; v++) begin
      wr(7, 8'(v));
      rd_chk("R12 scratch", 7, 8'(v));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule